// File: doc/BRIEF.md
# Sensor Front-End Initialization Sequencer

This controller brings an image-sensor timing generator and analog front end out of power-up. A host pulses a start request. The sequencer then waits until the master clock and both sync inputs are reported present. After that it sends a fixed, ordered series of register writes to a downstream serial write engine. Each write is one address/data request that uses a valid/ready handshake.

The list begins with a reset pulse to the timing core, written as two register writes: 0 and then 1. Two initialization constants follow, and then a write that locks register updates. The sequencer then stops in a configuration window, where the host can load its own timing registers through the same serial engine. When the host pulses a configuration-done input, the sequencer enables the clock outputs and releases the update lock. It reports whether it is busy, whether it has finished, and the index of the write it is working on.

Top module: `sfi_init_seq`

## Requirements
- R1: A synchronous active-low reset puts the block in idle: `wr_valid` low, `busy` low, `done` low, `step` equal to 0.
- R2: `busy` is high from the cycle after an accepted start until the last write is accepted. No write request is raised in the first cycle after start.
- R3: The accepted writes, in this order, are (address, data): (0x026, 0), (0x026, 1), (0x020, 53), (0x00F, 4), (0x019, 1), (0x016, 1), (0x019, 0). Data is zero-extended to the data width.
- R4: A raised request keeps its address and data and stays raised until it is accepted. The sequencer advances only in a cycle where `wr_valid` and `wr_ready` are both high.
- R5: After the lock write (0x019, 1) is accepted, no request is raised until `cfg_done` is seen high. A `cfg_done` pulse in any other state has no effect.
- R6: In the cycle after the final write is accepted, `done` goes high, `busy` goes low and `step` equals 7.
- R7: A start pulse while busy is ignored. A start pulse when done begins a new run from step 0 and clears `done`.
- R8: `step` gives the index (0 to 6) of the pending write. It reads 5 while waiting in the configuration window.
- R9: A start request is held while `clk_ok` is low. The first write is raised in the cycle after `clk_ok` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle start request |
| clk_ok | input | 1 | Master clock and sync inputs present |
| cfg_done | input | 1 | Host has finished loading its configuration |
| wr_ready | input | 1 | Serial write engine can accept a request |
| wr_valid | output | 1 | Write request pending |
| wr_addr | output | ADDR_W | Register address of the pending write |
| wr_data | output | DATA_W | Data of the pending write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| step | output | IDX_W | Index of the pending write |

## Verification
The hardest case to reach from the ports is a request held while the engine refuses it. A second difficult case is a stray start or configuration-done pulse that arrives while a write is still outstanding. To reach both, the bench drives `wr_ready` with a periodic stall pattern and pulses `start` and `cfg_done` in the middle of the issue phase. A cycle-level reference model follows every clock, and a log of accepted writes is compared against the required list. A reset in the middle of a run and a restart from the finished state exercise both exits from a run.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

   localparam int unsigned SFI_NUM_STEPS = 7;
   localparam int unsigned SFI_HOLD_IDX  = 4;
   localparam int unsigned SFI_RAW_AW    = 12;
   localparam int unsigned SFI_RAW_DW    = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARM   = 3'd1,
      ST_ISSUE = 3'd2,
      ST_HOLD  = 3'd3,
      ST_DONE  = 3'd4
   } sfi_state_e;

   typedef struct packed {
      logic [SFI_RAW_AW-1:0] addr;
      logic [SFI_RAW_DW-1:0] data;
   } sfi_wr_t;

   // bring-up write list; order is behaviour
   function automatic sfi_wr_t sfi_step(input int unsigned idx);
      sfi_wr_t w;
      case (idx)
         0:       begin w.addr = 12'h026; w.data = 8'd0;  end
         1:       begin w.addr = 12'h026; w.data = 8'd1;  end
         2:       begin w.addr = 12'h020; w.data = 8'd53; end
         3:       begin w.addr = 12'h00F; w.data = 8'd4;  end
         4:       begin w.addr = 12'h019; w.data = 8'd1;  end
         5:       begin w.addr = 12'h016; w.data = 8'd1;  end
         6:       begin w.addr = 12'h019; w.data = 8'd0;  end
         default: begin w.addr = '0;      w.data = '0;    end
      endcase
      return w;
   endfunction

endpackage

// File: rtl/sfi_step_table.sv
module sfi_step_table
   import sfi_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_STEPS = SFI_NUM_STEPS,
   parameter int unsigned IDX_W     = $clog2(NUM_STEPS + 1)
) (
   input  logic [IDX_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int unsigned LUT_AW = (ADDR_W < SFI_RAW_AW) ? ADDR_W : SFI_RAW_AW;
   localparam int unsigned LUT_DW = (DATA_W < SFI_RAW_DW) ? DATA_W : SFI_RAW_DW;

   logic [ADDR_W-1:0] lut_addr [NUM_STEPS];
   logic [DATA_W-1:0] lut_data [NUM_STEPS];

   generate
      if (ADDR_W < 10) begin : g_addr_chk
         $error("sfi_step_table: ADDR_W too narrow for register map");
      end
      if (DATA_W < 6) begin : g_data_chk
         $error("sfi_step_table: DATA_W too narrow for init constants");
      end
      for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_lut
         localparam sfi_wr_t ENT = sfi_step(gi);
         if (ADDR_W > LUT_AW) begin : g_aext
            assign lut_addr[gi] = {{(ADDR_W-LUT_AW){1'b0}}, ENT.addr[LUT_AW-1:0]};
         end else begin : g_aeq
            assign lut_addr[gi] = ENT.addr[LUT_AW-1:0];
         end
         if (DATA_W > LUT_DW) begin : g_dext
            assign lut_data[gi] = {{(DATA_W-LUT_DW){1'b0}}, ENT.data[LUT_DW-1:0]};
         end else begin : g_deq
            assign lut_data[gi] = ENT.data[LUT_DW-1:0];
         end
      end
   endgenerate

   always_comb begin
      addr_o = '0;
      data_o = '0;
      for (int i = 0; i < NUM_STEPS; i++) begin
         if (idx_i == IDX_W'(i)) begin
            addr_o = lut_addr[i];
            data_o = lut_data[i];
         end
      end
   end

endmodule

// File: rtl/sfi_seq_ctrl.sv
module sfi_seq_ctrl
   import sfi_pkg::*;
#(
   parameter int unsigned NUM_STEPS = SFI_NUM_STEPS,
   parameter int unsigned HOLD_IDX  = SFI_HOLD_IDX,
   parameter int unsigned IDX_W     = $clog2(NUM_STEPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             clk_ok_i,
   input  logic             cfg_done_i,
   input  logic             accept_i,
   output logic             issue_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] step_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);
   localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(HOLD_IDX);
   localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(NUM_STEPS);

   generate
      if (HOLD_IDX >= NUM_STEPS - 1) begin : g_hold_chk
         $error("sfi_seq_ctrl: hold point must precede the last write");
      end
   endgenerate

   sfi_state_e       st_q, st_d;
   logic [IDX_W-1:0] step_q, step_d;

   always_comb begin
      st_d   = st_q;
      step_d = step_q;
      unique case (st_q)
         ST_IDLE, ST_DONE: begin
            if (start_i) begin
               st_d   = ST_ARM;
               step_d = '0;
            end
         end
         ST_ARM: begin
            if (clk_ok_i) st_d = ST_ISSUE;
         end
         ST_ISSUE: begin
            if (accept_i) begin
               if (step_q == LOCK_IDX) begin
                  st_d   = ST_HOLD;
                  step_d = step_q + 1'b1;
               end else if (step_q == LAST_IDX) begin
                  st_d   = ST_DONE;
                  step_d = END_IDX;
               end else begin
                  step_d = step_q + 1'b1;
               end
            end
         end
         ST_HOLD: begin
            if (cfg_done_i) st_d = ST_ISSUE;
         end
         default: begin
            st_d   = ST_IDLE;
            step_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         step_q <= '0;
      end else begin
         st_q   <= st_d;
         step_q <= step_d;
      end
   end

   assign issue_o = (st_q == ST_ISSUE);
   assign busy_o  = (st_q == ST_ARM) || (st_q == ST_ISSUE) || (st_q == ST_HOLD);
   assign done_o  = (st_q == ST_DONE);
   assign step_o  = step_q;

   // R4
   step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == ST_ISSUE && step_q != $past(step_q)) |-> $past(accept_i));

   // R5
   hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == ST_HOLD && !$past(cfg_done_i)) |-> st_q == ST_HOLD);

   // R2
   no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !issue_o);

   // R6
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !issue_o && step_q == END_IDX));

   // R8
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> step_q <= LAST_IDX);

endmodule

// File: rtl/sfi_wr_port.sv
module sfi_wr_port #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              accept_o
);

   assign valid_o  = issue_i;
   assign addr_o   = issue_i ? addr_i : '0;
   assign data_o   = issue_i ? data_i : '0;
   assign accept_o = issue_i && ready_i;

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/sfi_init_seq.sv
module sfi_init_seq
   import sfi_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_STEPS = SFI_NUM_STEPS,
   parameter int unsigned HOLD_IDX  = SFI_HOLD_IDX,
   parameter int unsigned IDX_W     = $clog2(NUM_STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              clk_ok,
   input  logic              cfg_done,
   input  logic              wr_ready,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic [IDX_W-1:0]  step
);

   generate
      if (NUM_STEPS != SFI_NUM_STEPS) begin : g_len_chk
         $error("sfi_init_seq: NUM_STEPS must match the write list");
      end
   endgenerate

   logic              issue;
   logic              accept;
   logic [ADDR_W-1:0] tbl_addr;
   logic [DATA_W-1:0] tbl_data;

   sfi_seq_ctrl #(
      .NUM_STEPS (NUM_STEPS),
      .HOLD_IDX  (HOLD_IDX),
      .IDX_W     (IDX_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .clk_ok_i   (clk_ok),
      .cfg_done_i (cfg_done),
      .accept_i   (accept),
      .issue_o    (issue),
      .busy_o     (busy),
      .done_o     (done),
      .step_o     (step)
   );

   sfi_step_table #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_STEPS (NUM_STEPS),
      .IDX_W     (IDX_W)
   ) u_table (
      .idx_i  (step),
      .addr_o (tbl_addr),
      .data_o (tbl_data)
   );

   sfi_wr_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_i  (issue),
      .addr_i   (tbl_addr),
      .data_i   (tbl_data),
      .ready_i  (wr_ready),
      .valid_o  (wr_valid),
      .addr_o   (wr_addr),
      .data_o   (wr_data),
      .accept_o (accept)
   );

   // R3
   first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wr_valid) && step == '0) |-> (wr_addr == ADDR_W'(12'h026) && wr_data == '0));

endmodule

// File: tb/tb_sfi_init_seq.sv
module tb_sfi_init_seq;

   localparam int AW = 12;
   localparam int DW = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          clk_ok = 1'b0;
   logic          cfg_done = 1'b0;
   logic          wr_ready = 1'b0;
   logic          wr_valid;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          busy;
   logic          done;
   logic [IW-1:0] step;

   always #2 clk = ~clk;

   sfi_init_seq dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .clk_ok   (clk_ok),
      .cfg_done (cfg_done),
      .wr_ready (wr_ready),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .busy     (busy),
      .done     (done),
      .step     (step)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int ready_mode = 0;
   bit cmp_en = 1'b0;

   int exp_a [7] = '{'h026, 'h026, 'h020, 'h00F, 'h019, 'h016, 'h019};
   int exp_d [7] = '{0, 1, 53, 4, 1, 1, 0};

   int m_st   = 0;
   int m_step = 0;
   int log_a [$];
   int log_d [$];

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference model, advanced on every edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = 0; m_step = 0;
      end else begin
         case (m_st)
            0, 4: if (start) begin m_st = 1; m_step = 0; end
            1: if (clk_ok) m_st = 2;
            2: if (wr_ready) begin
                  if (m_step == 4) begin m_st = 3; m_step = 5; end
                  else if (m_step == 6) begin m_st = 4; m_step = 7; end
                  else m_step++;
               end
            3: if (cfg_done) m_st = 2;
            default: m_st = 0;
         endcase
      end
   end

   // compare every cycle and log accepts, away from the active edge
   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R4", "wr_valid", int'(wr_valid), int'(m_st == 2));
         chk("R2", "busy", int'(busy), int'(m_st == 1 || m_st == 2 || m_st == 3));
         chk("R6", "done", int'(done), int'(m_st == 4));
         chk("R8", "step", int'(step), m_step);
         if (m_st == 2) begin
            chk("R3", "wr_addr", int'(wr_addr), exp_a[m_step]);
            chk("R3", "wr_data", int'(wr_data), exp_d[m_step]);
         end
         if (rst_n && wr_valid && wr_ready) begin
            log_a.push_back(int'(wr_addr));
            log_d.push_back(int'(wr_data));
         end
      end
   end

   // ready driver: always high or a periodic stall pattern
   initial begin
      forever begin
         @(negedge clk);
         wr_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      end
   end

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_cfg();
      @(negedge clk); cfg_done = 1'b1;
      @(negedge clk); cfg_done = 1'b0;
   endtask

   task automatic wait_hold();
      for (int i = 0; i < 300; i++) begin
         if (busy && !wr_valid && step == 3'd5) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_done();
      for (int i = 0; i < 300; i++) begin
         if (done) break;
         @(negedge clk);
      end
   endtask

   task automatic check_log();
      chk("R3", "accepted count", log_a.size(), 7);
      for (int i = 0; i < 7 && i < log_a.size(); i++) begin
         chk("R3", "logged addr", log_a[i], exp_a[i]);
         chk("R3", "logged data", log_d[i], exp_d[i]);
      end
   endtask

   initial begin
      int s0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      cmp_en = 1'b1;
      // R1 reset state
      chk("R1", "valid after reset", int'(wr_valid), 0);
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "step after reset", int'(step), 0);
      rst_n = 1'b1;

      // run A: clocks not ready at start, stalling engine
      ready_mode = 1;
      pulse_start();
      wait_cyc(5);
      // R9 start held while clk_ok low
      chk("R9", "no request without clk_ok", int'(wr_valid), 0);
      chk("R9", "busy while waiting for clk_ok", int'(busy), 1);
      clk_ok = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9", "first request after clk_ok", int'(wr_valid), 1);
      wait_hold();
      wait_cyc(6);
      // R5 window holds until cfg_done
      chk("R5", "no request in window", int'(wr_valid), 0);
      chk("R5", "step in window", int'(step), 5);
      pulse_cfg();
      wait_done();
      chk("R6", "done after final write", int'(done), 1);
      chk("R6", "busy cleared at done", int'(busy), 0);
      chk("R6", "step at done", int'(step), 7);
      check_log();

      // run B: start from done, stray start and cfg_done mid-run
      log_a.delete(); log_d.delete();
      ready_mode = 0;
      pulse_start();
      // R7 restart from done clears done
      chk("R7", "done cleared on restart", int'(done), 0);
      chk("R7", "restart from step 0", int'(step), 0);
      wait_cyc(2);
      s0 = int'(step);
      pulse_start();
      // R7 start while busy ignored
      chk("R7", "step not rewound by start", int'(step >= 3'(s0)), 1);
      pulse_cfg();
      wait_hold();
      chk("R5", "early cfg_done ignored", int'(step), 5);
      wait_cyc(3);
      chk("R5", "still parked", int'(wr_valid), 0);
      pulse_cfg();
      wait_done();
      chk("R6", "done in run B", int'(done), 1);
      check_log();

      // run C: reset in the middle of a run
      ready_mode = 1;
      pulse_start();
      wait_cyc(4);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "valid after mid-run reset", int'(wr_valid), 0);
      chk("R1", "busy after mid-run reset", int'(busy), 0);
      chk("R1", "step after mid-run reset", int'(step), 0);
      rst_n = 1'b1;
      wait_cyc(3);
      chk("R1", "idle stays idle", int'(busy), 0);

      wait_cyc(2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule